// File: doc/BRIEF.md
# UART XON/XOFF Flow Controller

This block runs in-band (software) flow control next to a byte-wide UART receiver and transmitter. It watches the receive FIFO fill count. When the FIFO is filling up, it asks the transmitter to insert a stop character. When the FIFO has drained again, it asks for a resume character. It also inspects every received byte for the programmed stop and resume codes. A stop code pauses local transmission and a resume code releases it. Matching bytes can optionally be removed from the stream handed onward.

Received bytes enter on a valid/ready stream and leave on a second valid/ready stream. A byte that passes is forwarded combinationally: `dn_valid` follows `up_valid`, and `up_ready` follows `dn_ready`, so back-pressure from downstream reaches the receiver unchanged. A byte that is stripped is accepted at once (`up_ready` high) and never appears downstream. Flow characters leave on a request/grant pair. `fc_valid` and `fc_char` hold steady until the transmitter pulses `fc_grant` at a character boundary. A flow character has priority over queued data. `tx_hold` tells the transmitter to hold its data bytes.

Two controls override the received state:
- A one-cycle `force_stop` pauses transmission.
- A one-cycle `force_go` resumes it.

One-shot `send_on` and `send_off` pulses queue a resume or stop character. Each queued request clears itself when it is granted. The whole function works only while `fc_enable` is high.

Top module: `swfc_ctrl`

## Requirements
- R1: With `fc_enable` low, bytes pass unchanged (`dn_valid`=`up_valid`, `up_ready`=`dn_ready`). In that mode no event pulses, `fc_valid` stays 0, and `tx_hold` is 0 one cycle after `fc_enable` falls.
- R2: With `fc_enable` high and no stop sent yet, `fill` strictly greater than `off_level` raises `fc_valid`, with `fc_char`=`off_code`, one cycle later. `fill` equal to `off_level` raises nothing.
- R3: After a stop has been requested, `fill` strictly below `on_level` raises `fc_valid` with `fc_char`=`on_code` one cycle later. A low `fill` with no prior stop raises nothing.
- R4: While in the stop-sent state, `fill` staying above `off_level` does not request another stop after the first one is granted.
- R5: A consumed byte equal to `off_code` sets `tx_hold` on the next cycle. A consumed byte equal to `on_code` clears it on the next cycle.
- R6: With `strip` high, a byte equal to either code is accepted with `up_ready`=1 and `dn_valid`=0. With `strip` low, such a byte is forwarded like any other.
- R7: A consumed `off_code` byte gives a one-cycle `ev_off` pulse on the next cycle, and an `on_code` byte gives a one-cycle `ev_on` pulse.
- R8: `force_stop` sets `tx_hold` next cycle and `force_go` clears it. Both win over a received code in the same cycle, and `force_stop` wins over `force_go`.
- R9: A `send_on` or `send_off` pulse queues that character. `fc_valid` holds until `fc_grant`, and the granted request clears itself. When both are pending, `off_code` is offered first.
- R10: For a non-code byte, `up_ready` equals `dn_ready`, and `dn_data` equals `up_data` whenever `dn_valid` is high.
- R11: Synchronous active-high `rst` clears `tx_hold`, the event flags, the stop-sent state and all pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_enable | input | 1 | Enables the whole flow-control function |
| strip | input | 1 | Drop received flow codes from the stream |
| on_code | input | 8 | Resume character |
| off_code | input | 8 | Stop character |
| off_level | input | 9 | Fill above this requests a stop |
| on_level | input | 9 | Fill below this requests a resume |
| fill | input | 9 | Receive FIFO byte count |
| up_valid | input | 1 | Received byte valid |
| up_ready | output | 1 | Received byte accepted |
| up_data | input | 8 | Received byte |
| dn_valid | output | 1 | Filtered byte valid |
| dn_ready | input | 1 | Downstream can take a byte |
| dn_data | output | 8 | Filtered byte |
| force_stop | input | 1 | Pulse: pause transmission |
| force_go | input | 1 | Pulse: resume transmission |
| send_on | input | 1 | Pulse: queue a resume character |
| send_off | input | 1 | Pulse: queue a stop character |
| fc_valid | output | 1 | Flow character waiting for the transmitter |
| fc_char | output | 8 | Flow character to insert |
| fc_grant | input | 1 | Transmitter took `fc_char` |
| tx_hold | output | 1 | Transmitter must hold data bytes |
| ev_on | output | 1 | Resume code received (one cycle) |
| ev_off | output | 1 | Stop code received (one cycle) |

## Verification
The assertions assume the following about the inputs:
- The transmitter pulses `fc_grant` only while `fc_valid` is high.
- `on_code` and `off_code` differ.
- The thresholds hold `on_level` at or below `off_level`.

The directed stimulus keeps to these rules. It changes codes and levels only between scenarios, and it drives every input on the falling clock edge, so the combinational stream path is sampled settled.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic {PICK_ON = 1'b0, PICK_OFF = 1'b1} fc_pick_e;
endpackage

// File: rtl/swfc_rx_scan.sv
module swfc_rx_scan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              strip,
  input  logic [DATA_W-1:0] on_code,
  input  logic [DATA_W-1:0] off_code,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  input  logic              force_stop,
  input  logic              force_go,
  output logic              tx_hold,
  output logic              ev_on,
  output logic              ev_off
);
  logic hit_on, hit_off, drop, take;

  always_comb begin
    hit_on   = en && (up_data == on_code);
    hit_off  = en && (up_data == off_code);
    drop     = strip && (hit_on || hit_off);
    dn_valid = up_valid && !drop;
    dn_data  = up_data;
    up_ready = drop || dn_ready;
    take     = up_valid && up_ready;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tx_hold <= 1'b0;
      ev_on   <= 1'b0;
      ev_off  <= 1'b0;
    end else begin
      ev_on  <= take && hit_on;
      ev_off <= take && hit_off;
      if (force_stop)          tx_hold <= 1'b1;
      else if (force_go)       tx_hold <= 1'b0;
      else if (take && hit_off) tx_hold <= 1'b1;
      else if (take && hit_on)  tx_hold <= 1'b0;
    end
  end

  assert_force_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (en && force_stop) |=> tx_hold);
  assert_force_go_R8: assert property (@(posedge clk) disable iff (rst)
    (en && force_go && !force_stop) |=> !tx_hold);
  assert_off_code_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !force_go && up_valid && up_ready && up_data == off_code) |=> tx_hold);
  assert_ev_single_R7: assert property (@(posedge clk) disable iff (rst)
    ev_off |=> !ev_off || $past(up_valid && up_ready));
  assert_dis_release_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tx_hold && !ev_on && !ev_off));
  always_comb begin
    if (!rst && dn_valid && en && strip)
      assert_stripped_gone_R6: assert (dn_data != on_code && dn_data != off_code);
  end
endmodule

// File: rtl/swfc_tx_inject.sv
module swfc_tx_inject
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] on_code,
  input  logic [DATA_W-1:0] off_code,
  input  logic [CNT_W-1:0]  off_level,
  input  logic [CNT_W-1:0]  on_level,
  input  logic [CNT_W-1:0]  fill,
  input  logic              send_on,
  input  logic              send_off,
  output logic              fc_valid,
  output logic [DATA_W-1:0] fc_char,
  input  logic              fc_grant
);
  logic     off_sent, pend_on, pend_off;
  logic     cross_hi, cross_lo, take_on, take_off;
  fc_pick_e pick;

  always_comb begin
    cross_hi = en && !off_sent && (fill > off_level);
    cross_lo = en && off_sent && (fill < on_level);
    pick     = pend_off ? PICK_OFF : PICK_ON;
    fc_valid = pend_on || pend_off;
    fc_char  = (pick == PICK_OFF) ? off_code : on_code;
    take_off = fc_grant && pend_off;
    take_on  = fc_grant && !pend_off && pend_on;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      off_sent <= 1'b0;
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
    end else begin
      if (cross_hi)      off_sent <= 1'b1;
      else if (cross_lo) off_sent <= 1'b0;
      pend_off <= (pend_off && !take_off && !cross_lo) || cross_hi || send_off;
      pend_on  <= (pend_on && !take_on && !cross_hi) || cross_lo || send_on;
    end
  end

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (en && fc_valid && !fc_grant) |=> fc_valid);
  assert_dis_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !fc_valid);
  assert_no_resend_R4: assert property (@(posedge clk) disable iff (rst)
    (en && off_sent && !pend_off && !send_off) |=> !pend_off);
  assert_off_first_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_on && pend_off) |-> fc_char == off_code);
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fc_enable,
  input  logic              strip,
  input  logic [DATA_W-1:0] on_code,
  input  logic [DATA_W-1:0] off_code,
  input  logic [CNT_W-1:0]  off_level,
  input  logic [CNT_W-1:0]  on_level,
  input  logic [CNT_W-1:0]  fill,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  input  logic              force_stop,
  input  logic              force_go,
  input  logic              send_on,
  input  logic              send_off,
  output logic              fc_valid,
  output logic [DATA_W-1:0] fc_char,
  input  logic              fc_grant,
  output logic              tx_hold,
  output logic              ev_on,
  output logic              ev_off
);
  swfc_rx_scan #(.DATA_W(DATA_W)) u_scan (
    .clk(clk), .rst(rst), .en(fc_enable), .strip(strip),
    .on_code(on_code), .off_code(off_code),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .force_stop(force_stop), .force_go(force_go),
    .tx_hold(tx_hold), .ev_on(ev_on), .ev_off(ev_off)
  );

  swfc_tx_inject #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_inject (
    .clk(clk), .rst(rst), .en(fc_enable),
    .on_code(on_code), .off_code(off_code),
    .off_level(off_level), .on_level(on_level), .fill(fill),
    .send_on(send_on), .send_off(send_off),
    .fc_valid(fc_valid), .fc_char(fc_char), .fc_grant(fc_grant)
  );

  assert_pass_R10: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (up_valid && dn_data == up_data));
endmodule

// File: tb/tb_swfc_ctrl.sv
module tb_swfc_ctrl;
  localparam logic [7:0] ON_C = 8'h11, OFF_C = 8'h13;
  logic clk = 1'b0, rst = 1'b1;
  logic fc_enable = 1'b0, strip = 1'b0;
  logic [7:0] on_code = ON_C, off_code = OFF_C;
  logic [8:0] off_level = 9'd100, on_level = 9'd20, fill = 9'd50;
  logic up_valid = 1'b0, dn_ready = 1'b1;
  logic [7:0] up_data = 8'h00;
  logic force_stop = 1'b0, force_go = 1'b0, send_on = 1'b0, send_off = 1'b0, fc_grant = 1'b0;
  logic up_ready, dn_valid, fc_valid, tx_hold, ev_on, ev_off;
  logic [7:0] dn_data, fc_char;
  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  swfc_ctrl dut (
    .clk(clk), .rst(rst), .fc_enable(fc_enable), .strip(strip),
    .on_code(on_code), .off_code(off_code), .off_level(off_level), .on_level(on_level),
    .fill(fill), .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .force_stop(force_stop), .force_go(force_go), .send_on(send_on), .send_off(send_off),
    .fc_valid(fc_valid), .fc_char(fc_char), .fc_grant(fc_grant),
    .tx_hold(tx_hold), .ev_on(ev_on), .ev_off(ev_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1; tick; tick; rst = 1'b0;
  endtask

  task automatic t_reset;
    fc_enable = 1'b1; force_stop = 1'b1; send_off = 1'b1; tick;
    force_stop = 1'b0; send_off = 1'b0;
    rst = 1'b1; tick; rst = 1'b0;
    chk("R11 hold", tx_hold, 0);
    chk("R11 req", fc_valid, 0);
    chk("R11 ev", {ev_on, ev_off}, 0);
    fill = 9'd0; tick; tick;
    chk("R3 no resume without stop", fc_valid, 0);
    fill = 9'd50; tick;
  endtask

  task automatic t_disabled;
    fc_enable = 1'b1; force_stop = 1'b1; tick; force_stop = 1'b0;
    chk("R8 hold set", tx_hold, 1);
    fc_enable = 1'b0; tick;
    chk("R1 hold released", tx_hold, 0);
    strip = 1'b1; fill = 9'd300; up_valid = 1'b1; up_data = OFF_C; dn_ready = 1'b1; #1;
    chk("R1 code passes", dn_valid, 1);
    tick; up_valid = 1'b0;
    chk("R1 no event", ev_off, 0);
    chk("R1 no hold", tx_hold, 0);
    chk("R1 no request", fc_valid, 0);
    strip = 1'b0; fill = 9'd50; fc_enable = 1'b1; tick;
  endtask

  task automatic t_thresholds;
    fill = 9'd100; tick;
    chk("R2 equal no stop", fc_valid, 0);
    fill = 9'd101; tick;
    chk("R2 stop valid", fc_valid, 1);
    chk("R2 stop char", fc_char, OFF_C);
    tick;
    chk("R9 held until grant", fc_valid, 1);
    fc_grant = 1'b1; tick; fc_grant = 1'b0;
    chk("R9 cleared on grant", fc_valid, 0);
    fill = 9'd150; tick; tick; tick;
    chk("R4 no resend", fc_valid, 0);
    fill = 9'd20; tick;
    chk("R3 equal no resume", fc_valid, 0);
    fill = 9'd19; tick;
    chk("R3 resume valid", fc_valid, 1);
    chk("R3 resume char", fc_char, ON_C);
    fc_grant = 1'b1; tick; fc_grant = 1'b0;
    chk("R3 resume granted", fc_valid, 0);
    fill = 9'd5; tick; tick;
    chk("R3 no second resume", fc_valid, 0);
    fill = 9'd50; tick;
  endtask

  task automatic t_codes;
    strip = 1'b0; dn_ready = 1'b1;
    up_valid = 1'b1; up_data = OFF_C; #1;
    chk("R6 code forwarded", dn_valid, 1);
    tick; up_valid = 1'b0;
    chk("R5 stop holds", tx_hold, 1);
    chk("R7 ev_off pulse", ev_off, 1);
    tick;
    chk("R7 ev_off one cycle", ev_off, 0);
    up_valid = 1'b1; up_data = ON_C; tick; up_valid = 1'b0;
    chk("R5 resume releases", tx_hold, 0);
    chk("R7 ev_on pulse", ev_on, 1);
    tick;
    chk("R7 ev_on one cycle", ev_on, 0);
  endtask

  task automatic t_strip;
    strip = 1'b1; dn_ready = 1'b0;
    up_valid = 1'b1; up_data = OFF_C; #1;
    chk("R6 stripped accepted", up_ready, 1);
    chk("R6 stripped not sent", dn_valid, 0);
    tick;
    chk("R5 stripped stop holds", tx_hold, 1);
    up_data = 8'h41; #1;
    chk("R10 data valid", dn_valid, 1);
    chk("R10 backpressure", up_ready, 0);
    chk("R10 data equal", dn_data, 8'h41);
    dn_ready = 1'b1; #1;
    chk("R10 ready follows", up_ready, 1);
    up_data = ON_C; tick; up_valid = 1'b0; strip = 1'b0;
    chk("R5 stripped resume", tx_hold, 0);
  endtask

  task automatic t_force;
    force_stop = 1'b1; up_valid = 1'b1; up_data = ON_C; tick;
    force_stop = 1'b0; up_valid = 1'b0;
    chk("R8 stop beats code", tx_hold, 1);
    force_go = 1'b1; up_valid = 1'b1; up_data = OFF_C; tick;
    force_go = 1'b0; up_valid = 1'b0;
    chk("R8 go beats code", tx_hold, 0);
    force_stop = 1'b1; force_go = 1'b1; tick;
    force_stop = 1'b0; force_go = 1'b0;
    chk("R8 stop beats go", tx_hold, 1);
    force_go = 1'b1; tick; force_go = 1'b0;
    chk("R8 go", tx_hold, 0);
  endtask

  task automatic t_send;
    send_on = 1'b1; tick; send_on = 1'b0;
    chk("R9 send_on valid", fc_valid, 1);
    chk("R9 send_on char", fc_char, ON_C);
    send_off = 1'b1; tick; send_off = 1'b0;
    chk("R9 off first", fc_char, OFF_C);
    fc_grant = 1'b1; tick; fc_grant = 1'b0;
    chk("R9 on remains", fc_valid, 1);
    chk("R9 on char", fc_char, ON_C);
    fc_grant = 1'b1; tick; fc_grant = 1'b0;
    chk("R9 all cleared", fc_valid, 0);
  endtask

  initial begin
    do_reset;
    t_reset;
    t_disabled;
    t_thresholds;
    t_codes;
    t_strip;
    t_force;
    t_send;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule